// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sampling Read Sequencer

This block sits on the host side of a parallel bus and runs a four-channel simultaneous-sampling converter. A free-running period timer asks for a new sample set at a fixed rate. On each request the sequencer drives a convert-start pulse and waits for the converter's active-low completion interrupt. It then performs four reads of one shared data address and presents each 12-bit word on a streaming output. Each word carries a channel index and a one-cycle valid strobe.

All bus timing minimums are parameters counted in system clock cycles: the start pulse width, the read low time, and the spacing between reads. The integrator rounds each one up from the converter's nanosecond figures at the chosen clock rate. A timer tick that arrives while a conversion or its reads are still in progress is dropped, so the converter never sees a second start before its four results have been read. If the interrupt never arrives, a timeout returns the sequencer to idle and raises a one-cycle error pulse.

Top module: `qs_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after reset, `cvt_start` is 0, `cs_n` and `rd_n` are 1, and `res_valid` and `tmo_err` are 0.
- R2: With a nonzero `period_cycles` value P, and with each conversion finished before the next tick, consecutive rising edges of `cvt_start` are exactly P cycles apart.
- R3: Each `cvt_start` pulse stays high for exactly START_HI cycles, and it rises only while `rd_n` and `cs_n` are both high.
- R4: A timer tick that occurs between a rising edge of `cvt_start` and the last result of that conversion (or its timeout) is dropped. The next start therefore falls on a later tick, a whole number of periods after the previous start.
- R5: Reads begin only after a falling edge of `irq_n`. The first `rd_n` fall comes exactly 3 cycles after `irq_n` falls, which covers two synchronizer stages and one edge-detect stage. No read is issued while `cvt_start` is high.
- R6: Each read holds `rd_n` low for exactly RD_LO cycles, and `cs_n` is low in every cycle in which `rd_n` is low.
- R7: Between consecutive reads of one conversion, `rd_n` stays high for exactly RD_GAP cycles.
- R8: Each conversion produces exactly NCH reads. Their results carry `res_ch` = 0, 1, 2, 3 in read order, where index 0 stands for the first converter channel.
- R9: `res_data` holds the value of `db` sampled at the clock edge that ends the read, that is, the last cycle with `rd_n` low. `res_valid` is a one-cycle pulse that appears in the same cycle in which `rd_n` returns high.
- R10: If `irq_n` does not fall within IRQ_TMO cycles after `cvt_start` falls, `tmo_err` pulses for one cycle exactly START_HI+IRQ_TMO cycles after the start rose. The sequencer returns to idle without issuing any read.
- R11: A falling edge of `irq_n` outside the wait-for-interrupt phase starts no read.
- R12: With `period_cycles` = 0 the timer is stopped and no `cvt_start` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_cycles | input | PERIOD_W | Sample-set period in clock cycles; 0 stops the timer |
| cvt_start | output | 1 | Convert-start pulse to the converter |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| irq_n | input | 1 | Active-low conversion-complete interrupt (asynchronous) |
| db | input | DATA_W | Converter data bus |
| res_data | output | DATA_W | Captured result word |
| res_ch | output | CH_W | Channel index of the result |
| res_valid | output | 1 | One-cycle result strobe |
| tmo_err | output | 1 | One-cycle pulse when the interrupt times out |

## Verification
The bench builds the block with START_HI=3, RD_LO=4, RD_GAP=5, IRQ_TMO=60 and a 12-bit period field. These small values bring the full conversion, the read train, the timeout path and a deliberately dropped tick into reach within a few hundred cycles each. A converter model drives valid data only from the third cycle of each read, so capturing the bus too early shows up as a wrong word. One vector uses a period shorter than the conversion, which exercises the dropped-tick rule together with the exact read timing.

// File: rtl/qs_pkg.sv
package qs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_READ,
    ST_GAP
  } qs_state_e;

  function automatic int qs_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/qs_period_timer.sv
module qs_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_cycles,
  output logic                tick
);

  logic [PERIOD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (period_cycles == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= period_cycles - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/qs_irq_sync.sv
module qs_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_n,
  output logic irq_fall
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], irq_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign irq_fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/qs_bus_fsm.sv
module qs_bus_fsm #(
  parameter int DATA_W   = 12,
  parameter int NCH      = 4,
  parameter int START_HI = 10,
  parameter int RD_LO    = 12,
  parameter int RD_GAP   = 26,
  parameter int IRQ_TMO  = 7200,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              irq_fall,
  input  logic [DATA_W-1:0] db,
  output logic              cvt_start,
  output logic              cs_n,
  output logic              rd_n,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_ch,
  output logic              res_valid,
  output logic              tmo_err
);

  import qs_pkg::*;

  localparam int CNT_MAX = qs_max4(START_HI, RD_LO, RD_GAP, IRQ_TMO);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] START_END = CNT_W'(START_HI - 1);
  localparam logic [CNT_W-1:0] READ_END  = CNT_W'(RD_LO - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(RD_GAP - 1);
  localparam logic [CNT_W-1:0] WAIT_END  = CNT_W'(IRQ_TMO - 1);
  localparam logic [CH_W-1:0]  LAST_CH   = CH_W'(NCH - 1);

  qs_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ch        <= '0;
      cvt_start <= 1'b0;
      cs_n      <= 1'b1;
      rd_n      <= 1'b1;
      res_data  <= '0;
      res_ch    <= '0;
      res_valid <= 1'b0;
      tmo_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      tmo_err   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (tick) begin
            state     <= ST_START;
            cvt_start <= 1'b1;
            cnt       <= '0;
          end
        end
        ST_START: begin
          if (cnt == START_END) begin
            state     <= ST_WAIT;
            cvt_start <= 1'b0;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (irq_fall) begin
            state <= ST_READ;
            cs_n  <= 1'b0;
            rd_n  <= 1'b0;
            ch    <= '0;
            cnt   <= '0;
          end else if (cnt == WAIT_END) begin
            state   <= ST_IDLE;
            tmo_err <= 1'b1;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (cnt == READ_END) begin
            res_data  <= db;
            res_ch    <= ch;
            res_valid <= 1'b1;
            rd_n      <= 1'b1;
            cs_n      <= 1'b1;
            cnt       <= '0;
            state     <= (ch == LAST_CH) ? ST_IDLE : ST_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == GAP_END) begin
            state <= ST_READ;
            cs_n  <= 1'b0;
            rd_n  <= 1'b0;
            ch    <= ch + 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state     <= ST_IDLE;
          cvt_start <= 1'b0;
          cs_n      <= 1'b1;
          rd_n      <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/qs_seq.sv
module qs_seq #(
  parameter int DATA_W   = 12,
  parameter int NCH      = 4,
  parameter int PERIOD_W = 16,
  parameter int START_HI = 10,
  parameter int RD_LO    = 12,
  parameter int RD_GAP   = 26,
  parameter int IRQ_TMO  = 7200,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_cycles,
  output logic                cvt_start,
  output logic                cs_n,
  output logic                rd_n,
  input  logic                irq_n,
  input  logic [DATA_W-1:0]   db,
  output logic [DATA_W-1:0]   res_data,
  output logic [CH_W-1:0]     res_ch,
  output logic                res_valid,
  output logic                tmo_err
);

  logic tick;
  logic irq_fall;

  qs_period_timer #(
    .PERIOD_W(PERIOD_W)
  ) u_timer (
    .clk           (clk),
    .rst           (rst),
    .period_cycles (period_cycles),
    .tick          (tick)
  );

  qs_irq_sync #(
    .STAGES(2)
  ) u_irq_sync (
    .clk      (clk),
    .rst      (rst),
    .irq_n    (irq_n),
    .irq_fall (irq_fall)
  );

  qs_bus_fsm #(
    .DATA_W   (DATA_W),
    .NCH      (NCH),
    .START_HI (START_HI),
    .RD_LO    (RD_LO),
    .RD_GAP   (RD_GAP),
    .IRQ_TMO  (IRQ_TMO)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .irq_fall  (irq_fall),
    .db        (db),
    .cvt_start (cvt_start),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .res_data  (res_data),
    .res_ch    (res_ch),
    .res_valid (res_valid),
    .tmo_err   (tmo_err)
  );

endmodule

// File: rtl/qs_seq_chk.sv
module qs_seq_chk #(
  parameter int NCH      = 4,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            cvt_start,
  input logic            cs_n,
  input logic            rd_n,
  input logic [CH_W-1:0] res_ch,
  input logic            res_valid,
  input logic            tmo_err
);

  logic            start_q;
  logic            rd_q;
  logic [7:0]      rd_cnt;
  logic [CH_W-1:0] exp_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      rd_q    <= 1'b1;
      rd_cnt  <= '0;
      exp_ch  <= '0;
    end else begin
      start_q <= cvt_start;
      rd_q    <= rd_n;
      if (cvt_start && !start_q) begin
        rd_cnt <= '0;
        exp_ch <= '0;
      end else begin
        if (!rd_n && rd_q) rd_cnt <= rd_cnt + 1'b1;
        if (res_valid) exp_ch <= exp_ch + 1'b1;
      end
    end
  end

  a_r6_cs_covers_read: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);

  a_r3_start_on_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    $rose(cvt_start) |-> (rd_n && cs_n));

  a_r4_start_after_full_set: assert property (@(posedge clk) disable iff (rst)
    $rose(cvt_start) |-> (rd_cnt == 8'd0 || rd_cnt == 8'(NCH)));

  a_r8_read_count_bound: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= 8'(NCH));

  a_r8_channel_order: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_ch == exp_ch));

  a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r9_valid_at_read_end: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $rose(rd_n));

  a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    tmo_err |=> !tmo_err);

  a_r10_err_without_read: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> (rd_n && cs_n && !cvt_start));

  a_r5_no_read_while_starting: assert property (@(posedge clk) disable iff (rst)
    cvt_start |-> rd_n);

endmodule

bind qs_seq qs_seq_chk #(
  .NCH(NCH)
) u_qs_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .cvt_start (cvt_start),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .res_ch    (res_ch),
  .res_valid (res_valid),
  .tmo_err   (tmo_err)
);

// File: tb/qs_seq_bench.sv
`timescale 1ns/1ps
module qs_seq_bench;

  localparam int DATA_W   = 12;
  localparam int NCH      = 4;
  localparam int PERIOD_W = 12;
  localparam int START_HI = 3;
  localparam int RD_LO    = 4;
  localparam int RD_GAP   = 5;
  localparam int IRQ_TMO  = 60;
  localparam int CH_W     = 2;

  // columns: period, conversion delay, data base, exact-interval flag
  localparam int NVEC = 3;
  localparam int VEC [NVEC][4] = '{
    '{200, 10, 'h100, 1},
    '{150, 30, 'h800, 1},
    '{ 40, 50, 'h0F0, 0}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [PERIOD_W-1:0] period_cycles = '0;
  logic                cvt_start, cs_n, rd_n, res_valid, tmo_err;
  logic                irq_n;
  logic [DATA_W-1:0]   db;
  logic [DATA_W-1:0]   res_data;
  logic [CH_W-1:0]     res_ch;

  always #2.5 clk = ~clk;

  qs_seq #(
    .DATA_W(DATA_W), .NCH(NCH), .PERIOD_W(PERIOD_W), .START_HI(START_HI),
    .RD_LO(RD_LO), .RD_GAP(RD_GAP), .IRQ_TMO(IRQ_TMO)
  ) u_qs_seq (
    .clk(clk), .rst(rst), .period_cycles(period_cycles),
    .cvt_start(cvt_start), .cs_n(cs_n), .rd_n(rd_n), .irq_n(irq_n), .db(db),
    .res_data(res_data), .res_ch(res_ch), .res_valid(res_valid), .tmo_err(tmo_err)
  );

  // ---------------- converter model ----------------
  int   conv_delay = 10;
  int   data_base  = 0;
  logic no_irq     = 1'b0;
  logic glitch     = 1'b0;
  logic m_irq_n    = 1'b1;
  logic m_start_q  = 1'b0;
  logic m_rd_q     = 1'b1;
  int   conv_left  = -1;
  int   rd_low     = 0;
  int   ridx       = 0;

  function automatic logic [DATA_W-1:0] word_for(input int base, input int k);
    return DATA_W'(base + k * 'h111);
  endfunction

  assign irq_n = m_irq_n & ~glitch;
  assign db    = (!rd_n && rd_low >= 2) ? word_for(data_base, ridx) : 12'hA5A;

  always @(posedge clk) begin
    if (rst) begin
      m_irq_n <= 1'b1; conv_left <= -1; rd_low <= 0; ridx <= 0;
      m_start_q <= 1'b0; m_rd_q <= 1'b1;
    end else begin
      m_start_q <= cvt_start;
      m_rd_q    <= rd_n;
      if (m_start_q && !cvt_start && !no_irq) conv_left <= conv_delay;
      else if (conv_left > 0) conv_left <= conv_left - 1;
      else if (conv_left == 0) begin m_irq_n <= 1'b0; conv_left <= -1; end
      if (m_rd_q && !rd_n) m_irq_n <= 1'b1;
      rd_low <= !rd_n ? rd_low + 1 : 0;
      if (!m_start_q && cvt_start) ridx <= 0;
      else if (!m_rd_q && rd_n) ridx <= ridx + 1;
    end
  end

  // ---------------- monitor ----------------
  int cyc, n_starts, t_start_prev, t_start_last, start_w_cur, start_w_last;
  int rd_w_cur, rd_bad, gap_cur, gap_bad, reads_in_conv, n_rdfalls, cs_bad;
  int nres, busy, busy_viol, n_err, t_err, t_irq_fall, t_rd_first;
  logic st_prev, rd_prev, irq_prev;
  int got_ch [8];
  int got_data [8];

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; n_starts = 0; t_start_prev = 0; t_start_last = 0; start_w_cur = 0;
      start_w_last = 0; rd_w_cur = 0; rd_bad = 0; gap_cur = 0; gap_bad = 0;
      reads_in_conv = 0; n_rdfalls = 0; cs_bad = 0; nres = 0; busy = 0;
      busy_viol = 0; n_err = 0; t_err = 0; t_irq_fall = 0; t_rd_first = 0;
      st_prev = 1'b0; rd_prev = 1'b1; irq_prev = 1'b1;
    end else begin
      cyc++;
      if (cvt_start && !st_prev) begin
        if (busy != 0) busy_viol++;
        busy = 1; n_starts++; t_start_prev = t_start_last; t_start_last = cyc;
        start_w_cur = 0; reads_in_conv = 0;
      end
      if (cvt_start) start_w_cur++;
      else if (st_prev) start_w_last = start_w_cur;
      if (!rd_n && rd_prev) begin
        n_rdfalls++;
        if (reads_in_conv > 0 && gap_cur != RD_GAP) gap_bad++;
        if (reads_in_conv == 0) t_rd_first = cyc;
        rd_w_cur = 0;
      end
      if (!rd_n) rd_w_cur++;
      else begin
        if (!rd_prev) begin
          if (rd_w_cur != RD_LO) rd_bad++;
          reads_in_conv++; gap_cur = 0;
        end
        gap_cur++;
      end
      if (!rd_n && cs_n) cs_bad++;
      if (!irq_n && irq_prev) t_irq_fall = cyc;
      if (res_valid) begin
        if (nres < 8) begin got_ch[nres] = int'(res_ch); got_data[nres] = int'(res_data); end
        nres++;
        if (res_ch == CH_W'(NCH - 1)) busy = 0;
      end
      if (tmo_err) begin n_err++; t_err = cyc; busy = 0; end
      st_prev = cvt_start; rd_prev = rd_n; irq_prev = irq_n;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input int p, input int conv, input int base, input bit noirq);
    @(posedge clk); #1;
    rst = 1'b1; period_cycles = PERIOD_W'(p); conv_delay = conv;
    data_base = base; no_irq = noirq; glitch = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin : main
    // R1: reset state
    period_cycles = PERIOD_W'(100);
    repeat (3) @(negedge clk);
    chk(cvt_start == 1'b0, "R1 start low", int'(cvt_start), 0);
    chk(cs_n && rd_n, "R1 bus idle", int'({cs_n, rd_n}), 3);
    chk(!res_valid && !tmo_err, "R1 no strobes", int'({res_valid, tmo_err}), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!cvt_start && rd_n && !res_valid, "R1 first cycle after reset",
        int'({cvt_start, rd_n, res_valid}), 2);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      start_run(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);
      while (!(n_starts >= 2 && nres >= NCH)) @(posedge clk);
      chk(nres == NCH, "R8 result count", nres, NCH);
      for (int k = 0; k < NCH; k++) begin
        chk(got_ch[k] == k, "R8 channel index", got_ch[k], k);
        chk(got_data[k] == int'(word_for(VEC[v][2], k)), "R9 captured word",
            got_data[k], int'(word_for(VEC[v][2], k)));
      end
      chk(start_w_last == START_HI, "R3 start width", start_w_last, START_HI);
      chk(rd_bad == 0, "R6 read low width", rd_bad, 0);
      chk(cs_bad == 0, "R6 select covers read", cs_bad, 0);
      chk(gap_bad == 0, "R7 read spacing", gap_bad, 0);
      chk(t_rd_first - t_irq_fall == 3, "R5 read after interrupt",
          t_rd_first - t_irq_fall, 3);
      chk(busy_viol == 0, "R4 no start while busy", busy_viol, 0);
      if (VEC[v][3] != 0) begin
        chk(t_start_last - t_start_prev == VEC[v][0], "R2 start interval",
            t_start_last - t_start_prev, VEC[v][0]);
      end else begin
        chk((t_start_last - t_start_prev) % VEC[v][0] == 0 &&
            (t_start_last - t_start_prev) >= 2 * VEC[v][0],
            "R4 dropped tick interval", t_start_last - t_start_prev, 2 * VEC[v][0]);
      end
    end

    // R10: interrupt never arrives
    start_run(300, 0, 0, 1'b1);
    while (n_err < 1) @(posedge clk);
    chk(t_err - t_start_last == START_HI + IRQ_TMO, "R10 timeout instant",
        t_err - t_start_last, START_HI + IRQ_TMO);
    repeat (5) @(posedge clk);
    chk(n_err == 1, "R10 single error pulse", n_err, 1);
    chk(n_rdfalls == 0 && nres == 0, "R10 no read after timeout", n_rdfalls + nres, 0);

    // R11 / R12: timer stopped, interrupt glitch while idle
    start_run(0, 0, 0, 1'b1);
    repeat (5) @(posedge clk);
    #1 glitch = 1'b1;
    repeat (6) @(posedge clk);
    #1 glitch = 1'b0;
    repeat (40) @(posedge clk);
    chk(n_starts == 0, "R12 no start with zero period", n_starts, 0);
    chk(n_rdfalls == 0 && nres == 0, "R11 idle interrupt ignored", n_rdfalls + nres, 0);

    $display("  Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

endmodule